// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block is the register file and control state of one bus-master disk DMA channel, as software sees it. Three registers sit behind a single-cycle word port: an 8-bit command register, an 8-bit status register and a 32-bit pointer to the descriptor table. The command register holds the run control and the transfer direction. The status register combines three kinds of bit. One is a live "transfer active" flag. Two are sticky error and interrupt flags that software clears by writing ones. Two are plain read/write flags that mark whether each of the two drive units may use DMA.

The descriptor-walking data engine is not part of this block. It appears only as three input strobes: transfer finished, transfer failed and drive interrupt. After the drive command has gone out, software sets the run bit. It then waits for the interrupt and stops the channel. Two combinational outputs report on the current status. The first is a completion code, which is zero only when the interrupt flag is set, the error flag is clear and the channel is idle; otherwise it is the status byte with a fault marker bit added. The second is a hold flag, raised while active and error are both set, which tells a timeout handler to keep waiting.

Top module: `bmdma_regs`

## Requirements
- R1: After reset every register reads zero, irq_o is low and busy_hold_o is low.
- R2: Command register (word address 0): bit 0 (run) and bit 3 (to-memory direction) read back exactly as last written. Every other bit reads zero. tomem_o follows bit 3.
- R3: Table pointer register (word address 2) holds 32 bits. Bits 1:0 always read zero, so the pointer is dword aligned.
- R4: Writing the command register with bit 0 = 1 sets status bit 0 (active) on the next cycle, but only if the table pointer is nonzero. With a zero pointer, active stays clear.
- R5: Active clears on the cycle after eng_done_i, after eng_err_i, or after a command write with bit 0 = 0.
- R6: Status bit 1 (error) sets on eng_err_i and status bit 2 (interrupt) sets on drv_irq_i. Both stay set until software clears them.
- R7: A status write (word address 1) with bit 1 or bit 2 at 1 clears that flag, and a 0 leaves it alone. When a set event arrives in the same cycle as the clearing write, the set wins.
- R8: Status bits 5 and 6 are read/write capability flags for drive units 0 and 1. A status write leaves bit 0 unchanged. Bits 3, 4 and 7 always read zero.
- R9: irq_o always equals status bit 2.
- R10: When status bits 2:0 equal 100b, end_ok_o is 1 and end_code_o is 0. For any other value, end_ok_o is 0 and end_code_o is the status byte OR 0x10.
- R11: busy_hold_o is 1 exactly when active and error are both set.
- R12: Word address 3 reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 2 | Register word address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| eng_done_i | input | 1 | Engine finished the transfer |
| eng_err_i | input | 1 | Engine hit a fault |
| drv_irq_i | input | 1 | Drive interrupt request |
| irq_o | output | 1 | Interrupt flag to the host |
| tomem_o | output | 1 | Direction: 1 = device to memory |
| end_ok_o | output | 1 | Current status counts as a good completion |
| end_code_o | output | 8 | 0 on good completion, else status OR 0x10 |
| busy_hold_o | output | 1 | Active and error both set |

## Verification
The assertions assume that each engine strobe lasts one cycle, and that a start request never arrives in the same cycle as done or error. The stimulus enforces this by pulsing each strobe once, between register writes. The only exception is the deliberate set-versus-clear collision in R7. Because the stimulus raises engine errors only while the channel is idle or about to be stopped, every reachable combination of active, error and interrupt can be built up before the completion code is checked.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [1:0] {
    RA_CMD  = 2'd0,
    RA_STAT = 2'd1,
    RA_PTR  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  localparam int CMD_RUN   = 0;
  localparam int CMD_TOMEM = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_INT    = 2;
  localparam int ST_FAULT  = 4;
  localparam int ST_DRV0   = 5;
  localparam int BYTE_W    = 8;
endpackage

// File: rtl/bmdma_cmd.sv
module bmdma_cmd
  import bmdma_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int ALIGN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              ptr_we_i,
  input  logic [PTR_W-1:0]  wdata_i,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              start_o,
  output logic              stop_o
);
  logic               run_q, tomem_q;
  logic [PTR_W-1:ALIGN] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      tomem_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      if (cmd_we_i) begin
        run_q   <= wdata_i[CMD_RUN];
        tomem_q <= wdata_i[CMD_TOMEM];
      end
      if (ptr_we_i) ptr_q <= wdata_i[PTR_W-1:ALIGN];
    end
  end

  // start needs a table to walk
  assign start_o = cmd_we_i && wdata_i[CMD_RUN] && (ptr_q != '0);
  assign stop_o  = cmd_we_i && !wdata_i[CMD_RUN];
  assign ptr_o   = {ptr_q, {ALIGN{1'b0}}};

  always_comb begin
    cmd_o            = '0;
    cmd_o[CMD_RUN]   = run_q;
    cmd_o[CMD_TOMEM] = tomem_q;
  end

  p_start_ptr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (ptr_o != '0));
endmodule

// File: rtl/bmdma_stat.sv
module bmdma_stat
  import bmdma_pkg::*;
#(
  parameter int N_DRV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stat_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              done_i,
  input  logic              err_i,
  input  logic              irq_i,
  output logic [BYTE_W-1:0] stat_o
);
  logic             act_q, err_q, int_q;
  logic [N_DRV-1:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      int_q <= 1'b0;
    end else begin
      if (start_i)                        act_q <= 1'b1;
      else if (stop_i || done_i || err_i) act_q <= 1'b0;
      // set beats write-one-to-clear
      if (err_i)                                err_q <= 1'b1;
      else if (stat_we_i && wdata_i[ST_ERR])    err_q <= 1'b0;
      if (irq_i)                                int_q <= 1'b1;
      else if (stat_we_i && wdata_i[ST_INT])    int_q <= 1'b0;
    end
  end

  for (genvar d = 0; d < N_DRV; d++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cap_q[d] <= 1'b0;
      else if (stat_we_i) cap_q[d] <= wdata_i[ST_DRV0+d];
    end
  end

  always_comb begin
    stat_o         = '0;
    stat_o[ST_ACT] = act_q;
    stat_o[ST_ERR] = err_q;
    stat_o[ST_INT] = int_q;
    for (int d = 0; d < N_DRV; d++) stat_o[ST_DRV0+d] = cap_q[d];
  end

  p_active_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(start_i));
  p_active_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stop_i || done_i || err_i) && !start_i) |=> !act_q);
  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(stat_we_i && wdata_i[ST_ERR])) |=> err_q);
  p_int_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && wdata_i[ST_INT] && !irq_i) |=> !int_q);
  p_int_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> int_q);
endmodule

// File: rtl/bmdma_end_chk.sv
module bmdma_end_chk
  import bmdma_pkg::*;
(
  input  logic [BYTE_W-1:0] stat_i,
  output logic              end_ok_o,
  output logic [BYTE_W-1:0] end_code_o,
  output logic              busy_hold_o
);
  always_comb begin
    end_ok_o   = stat_i[ST_INT] && !stat_i[ST_ERR] && !stat_i[ST_ACT];
    end_code_o = stat_i;
    end_code_o[ST_FAULT] = 1'b1;
    if (end_ok_o) end_code_o = '0;
    busy_hold_o = stat_i[ST_ACT] && stat_i[ST_ERR];
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int PTR_W = 32,
  parameter int ALIGN = 2,
  parameter int N_DRV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [PTR_W-1:0]  reg_wdata_i,
  output logic [PTR_W-1:0]  reg_rdata_o,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  input  logic              drv_irq_i,
  output logic              irq_o,
  output logic              tomem_o,
  output logic              end_ok_o,
  output logic [BYTE_W-1:0] end_code_o,
  output logic              busy_hold_o
);
  reg_addr_e         ra;
  logic [BYTE_W-1:0] cmd, stat;
  logic [PTR_W-1:0]  ptr;
  logic              start, stop;

  assign ra = reg_addr_e'(reg_addr_i);

  bmdma_cmd #(.PTR_W(PTR_W), .ALIGN(ALIGN)) i_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_we_i (reg_we_i && ra == RA_CMD),
    .ptr_we_i (reg_we_i && ra == RA_PTR),
    .wdata_i  (reg_wdata_i),
    .cmd_o    (cmd),
    .ptr_o    (ptr),
    .start_o  (start),
    .stop_o   (stop)
  );

  bmdma_stat #(.N_DRV(N_DRV)) i_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stat_we_i (reg_we_i && ra == RA_STAT),
    .wdata_i   (reg_wdata_i[BYTE_W-1:0]),
    .start_i   (start),
    .stop_i    (stop),
    .done_i    (eng_done_i),
    .err_i     (eng_err_i),
    .irq_i     (drv_irq_i),
    .stat_o    (stat)
  );

  bmdma_end_chk i_end (
    .stat_i      (stat),
    .end_ok_o    (end_ok_o),
    .end_code_o  (end_code_o),
    .busy_hold_o (busy_hold_o)
  );

  always_comb begin
    unique case (ra)
      RA_CMD:  reg_rdata_o = {{(PTR_W-BYTE_W){1'b0}}, cmd};
      RA_STAT: reg_rdata_o = {{(PTR_W-BYTE_W){1'b0}}, stat};
      RA_PTR:  reg_rdata_o = ptr;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o   = stat[ST_INT];
  assign tomem_o = cmd[CMD_TOMEM];

  p_end_ok_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_ok_o |-> (irq_o && !busy_hold_o));
  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && !start) |=> !busy_hold_o);
endmodule

// File: tb/test_bmdma_regs.sv
module test_bmdma_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        done = 1'b0, err = 1'b0, dirq = 1'b0;
  logic        irq, tomem, end_ok, busy_hold;
  logic [7:0]  end_code;
  int n_checks = 0, n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmdma_regs i_bmdma_regs (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .eng_done_i(done),
    .eng_err_i(err), .drv_irq_i(dirq), .irq_o(irq), .tomem_o(tomem),
    .end_ok_o(end_ok), .end_code_o(end_code), .busy_hold_o(busy_hold)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input logic p_done, input logic p_err, input logic p_irq);
    @(negedge clk); done = p_done; err = p_err; dirq = p_irq;
    @(negedge clk); done = 1'b0; err = 1'b0; dirq = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reset read", v, 32'h0);
    end
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 busy_hold", {31'b0, busy_hold}, 32'h0);
    chk("R10 reset end_code", {24'b0, end_code}, 32'h10);

    // R3 pointer alignment
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk("R3 ptr", v, 32'hFFFF_FFFC);
    wr(2'd2, 32'h1234_5677); rd(2'd2, v); chk("R3 ptr", v, 32'h1234_5674);
    wr(2'd2, 32'h0);

    // R2 command sweep with zero pointer; R4 no start
    for (int d = 0; d < 256; d++) begin
      wr(2'd0, 32'(d));
      rd(2'd0, v); chk("R2 cmd readback", v, 32'(d) & 32'h09);
      chk("R2 tomem", {31'b0, tomem}, 32'((d >> 3) & 1));
      rd(2'd1, v); chk("R4 zero ptr no start", v & 32'h1, 32'h0);
    end
    wr(2'd0, 32'h0);

    // R4 / R5 / R6 / R11 active control
    wr(2'd2, 32'h0000_1000);
    wr(2'd0, 32'h09); rd(2'd1, v); chk("R4 start", v, 32'h01);
    chk("R2 tomem set", {31'b0, tomem}, 32'h1);
    wr(2'd0, 32'h08); rd(2'd1, v); chk("R5 stop write", v, 32'h00);
    wr(2'd0, 32'h01); pulse(1'b1, 1'b0, 1'b0);
    rd(2'd1, v); chk("R5 done clears", v, 32'h00);
    wr(2'd0, 32'h01); pulse(1'b0, 1'b1, 1'b0);
    rd(2'd1, v); chk("R5 R6 err clears active, sets error", v, 32'h02);
    wr(2'd0, 32'h01); rd(2'd1, v); chk("R6 error sticky", v, 32'h03);
    chk("R11 busy_hold", {31'b0, busy_hold}, 32'h1);
    chk("R10 busy code", {24'b0, end_code}, 32'h13);
    wr(2'd0, 32'h00);
    chk("R11 busy_hold off", {31'b0, busy_hold}, 32'h0);
    wr(2'd1, 32'h06);

    // R7 / R8 / R9 status write sweep
    for (int d = 0; d < 256; d++) begin
      logic [31:0] e;
      pulse(1'b0, 1'b1, 1'b1);
      wr(2'd0, 32'h01);
      wr(2'd1, 32'(d));
      e = 32'h01 | (((d >> 1) & 1) == 0 ? 32'h02 : 0) |
          (((d >> 2) & 1) == 0 ? 32'h04 : 0) | (32'(d) & 32'h60);
      rd(2'd1, v); chk("R7 R8 status write", v, e);
      chk("R9 irq mirror", {31'b0, irq}, (e >> 2) & 1);
      wr(2'd0, 32'h00);
      wr(2'd1, 32'h06);
    end

    // R7 set beats clear
    @(negedge clk); addr = 2'd1; we = 1'b1; wdata = 32'h06; err = 1'b1; dirq = 1'b1;
    @(negedge clk); we = 1'b0; err = 1'b0; dirq = 1'b0;
    rd(2'd1, v); chk("R7 set wins", v, 32'h06);
    chk("R9 irq set", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'h06);
    rd(2'd1, v); chk("R7 cleared", v, 32'h00);
    chk("R9 irq clear", {31'b0, irq}, 32'h0);

    // R10 / R11 completion sweep over active, error, interrupt
    for (int c = 0; c < 8; c++) begin
      int a_b = c & 1, e_b = (c >> 1) & 1, i_b = (c >> 2) & 1;
      int s;
      if (e_b != 0) pulse(1'b0, 1'b1, 1'b0);
      if (i_b != 0) pulse(1'b0, 1'b0, 1'b1);
      if (a_b != 0) wr(2'd0, 32'h01);
      s = a_b | (e_b << 1) | (i_b << 2);
      @(negedge clk);
      chk("R10 end_ok", {31'b0, end_ok}, (s == 4) ? 32'h1 : 32'h0);
      chk("R10 end_code", {24'b0, end_code}, (s == 4) ? 32'h0 : 32'(s | 16));
      chk("R11 hold", {31'b0, busy_hold}, 32'(a_b & e_b));
      wr(2'd0, 32'h00);
      wr(2'd1, 32'h06);
    end

    // R12 unused address
    wr(2'd1, 32'h20); wr(2'd0, 32'h08);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R12 addr3 reads zero", v, 32'h0);
    rd(2'd0, v); chk("R12 cmd untouched", v, 32'h08);
    rd(2'd1, v); chk("R12 stat untouched", v, 32'h20);
    rd(2'd2, v); chk("R12 ptr untouched", v, 32'h0000_1000);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule